// File: doc/BRIEF.md
# Root Error Status Collector

This block sits at the root port of a PCIe-style hierarchy and gathers the error messages that arrive from downstream functions. Each message carries a severity (correctable, non-fatal or fatal) and a 16-bit requester identifier. The collector keeps the root error status flags, records the identifier of the first correctable message and the first uncorrectable message, and notes whether further messages of the same kind followed or whether the first uncorrectable error was fatal.

Software enables the three severity classes through a 3-bit root command value and clears status flags by writing ones. An interrupt is raised only when an enabled class becomes pending while no enabled class was pending before, so a burst of repeated errors produces a single notification. Delivery is by a one-cycle message pulse carrying a 5-bit vector when a message-signalled mode is on (the table-based mode wins over the plain one), or by a level line otherwise.

Top module: `root_err_collector`

## Requirements
- R1: After reset the command value, all status flags, both captured identifiers and the vector read zero, and `msg_irq`, `intx_level` and `sys_err` are low.
- R2: A correctable message (`msg_sev` = 0) sets status bit 0; if bit 0 was already set it sets bit 1 instead of capturing, otherwise it copies `msg_src` into `cor_src`.
- R3: A non-fatal (`msg_sev` = 1) or fatal (`msg_sev` = 2) message sets status bit 2; if bit 2 was already set it sets bit 3 and leaves `unc_src` unchanged, otherwise it copies `msg_src` into `unc_src`.
- R4: A fatal message always sets status bit 6 and sets bit 4 only when bit 2 was clear beforehand.
- R5: A non-fatal message sets status bit 5; a message with `msg_sev` = 3 changes no state and raises nothing.
- R6: The pending classes are bit 0 (correctable), bit 5 (non-fatal) and bit 6 (fatal), mapped to command bits 0, 1 and 2. A message notifies only if the command enables its severity and no pending class was enabled before it arrived.
- R7: In message mode (`msix_en` or `msi_en`) a notification is a one-cycle `msg_irq` pulse with `msg_irq_vec` equal to the stored vector; `msg_irq_msix` is 1 when `msix_en` is set, which takes precedence over `msi_en`.
- R8: With both message modes off and `intx_en` set, `intx_level` rises on a notification and, on every command write, becomes the OR of new command bits AND pending classes; it holds otherwise and is low whenever the level mode is not selected.
- R9: In message mode a command write pulses `msg_irq` only if no pending class was enabled by the old command and at least one is enabled by the new one.
- R10: `sts_clr` clears every status bit whose mask bit is 1; a bit set by a message in the same cycle stays set.
- R11: The vector changes only through `vec_wr`/`vec_wdata`; status clears and command writes leave it as it is.
- R12: An uncorrectable message while `serr_en` is 1 gives a one-cycle `sys_err` pulse; correctable messages never do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| msg_valid | input | 1 | An error message is present this cycle |
| msg_sev | input | 2 | 0 correctable, 1 non-fatal, 2 fatal, 3 ignored |
| msg_src | input | 16 | Requester identifier of the message |
| serr_en | input | 1 | System-error enable from the command register |
| cmd_wr | input | 1 | Write strobe for the root command value |
| cmd_wdata | input | 3 | New root command enables |
| sts_clr | input | 1 | Write-one-to-clear strobe for status |
| sts_clr_mask | input | 7 | Status bits to clear |
| vec_wr | input | 1 | Load strobe for the interrupt vector |
| vec_wdata | input | 5 | New interrupt vector |
| msix_en | input | 1 | Table-based message interrupts on |
| msi_en | input | 1 | Plain message interrupts on |
| intx_en | input | 1 | Level interrupt line allowed |
| root_cmd | output | 3 | Current command enables |
| root_sts | output | 7 | Status flags |
| cor_src | output | 16 | Identifier of first correctable message |
| unc_src | output | 16 | Identifier of first uncorrectable message |
| irq_vec | output | 5 | Stored interrupt vector |
| msg_irq | output | 1 | Message interrupt pulse |
| msg_irq_msix | output | 1 | Pulse goes out through the table-based mode |
| msg_irq_vec | output | 5 | Vector carried by the pulse |
| intx_level | output | 1 | Level interrupt line |
| sys_err | output | 1 | System error pulse |

## Verification
The hardest situation to reach is the suppression rule: a message of an enabled class arriving while a different, already enabled class is pending must stay silent, and a message of a disabled class must not arm a later one. The bench builds this by first leaving a correctable error pending under an all-disabled or partly enabled command, then sending a fatal message, and by rewriting the command to walk a pending class from disabled to enabled and back. Level-line behaviour is reached by switching both message modes off and probing the line after command writes.

// File: rtl/root_err_pkg.sv
package root_err_pkg;

    localparam int unsigned SRC_W = 16;
    localparam int unsigned VEC_W = 5;
    localparam int unsigned STS_W = 7;
    localparam int unsigned CLS_W = 3;

    // status flag positions
    localparam int unsigned B_COR      = 0;
    localparam int unsigned B_COR_MULT = 1;
    localparam int unsigned B_UNC      = 2;
    localparam int unsigned B_UNC_MULT = 3;
    localparam int unsigned B_FIRST_FT = 4;
    localparam int unsigned B_NF       = 5;
    localparam int unsigned B_FT       = 6;

    typedef enum logic [1:0] {
        SEV_COR  = 2'd0,
        SEV_NF   = 2'd1,
        SEV_FT   = 2'd2,
        SEV_NONE = 2'd3
    } sev_e;

    typedef struct packed {
        logic [CLS_W-1:0] cmd;
        logic [STS_W-1:0] sts;
        logic [SRC_W-1:0] cor_src;
        logic [SRC_W-1:0] unc_src;
        logic [VEC_W-1:0] vec;
        logic             irq;
        logic             irq_msix;
        logic [VEC_W-1:0] irq_vec;
        logic             intx;
        logic             serr;
    } rec_state_t;

    function automatic logic [CLS_W-1:0] pending_of(input logic [STS_W-1:0] s);
        return {s[B_FT], s[B_NF], s[B_COR]};
    endfunction

endpackage

// File: rtl/root_err_status.sv
module root_err_status
    import root_err_pkg::*;
(
    input  logic [STS_W-1:0] sts_q,
    input  logic [SRC_W-1:0] cor_src_q,
    input  logic [SRC_W-1:0] unc_src_q,
    input  logic             msg_valid,
    input  logic [1:0]       msg_sev,
    input  logic [SRC_W-1:0] msg_src,
    input  logic             clr_en,
    input  logic [STS_W-1:0] clr_mask,
    output logic [STS_W-1:0] sts_d,
    output logic [SRC_W-1:0] cor_src_d,
    output logic [SRC_W-1:0] unc_src_d
);

    logic [STS_W-1:0] set_v;
    logic [STS_W-1:0] keep_v;
    logic             is_cor;
    logic             is_unc;

    always_comb begin
        is_cor    = msg_valid && (sev_e'(msg_sev) == SEV_COR);
        is_unc    = msg_valid && ((sev_e'(msg_sev) == SEV_NF) || (sev_e'(msg_sev) == SEV_FT));
        set_v     = '0;
        cor_src_d = cor_src_q;
        unc_src_d = unc_src_q;

        if (is_cor) begin
            if (sts_q[B_COR]) begin
                set_v[B_COR_MULT] = 1'b1;
            end else begin
                cor_src_d = msg_src;
            end
            set_v[B_COR] = 1'b1;
        end

        if (is_unc) begin
            if (sts_q[B_UNC]) begin
                set_v[B_UNC_MULT] = 1'b1;
            end else begin
                unc_src_d = msg_src;
            end
            set_v[B_UNC] = 1'b1;
            if (sev_e'(msg_sev) == SEV_FT) begin
                set_v[B_FT] = 1'b1;
                if (!sts_q[B_UNC]) begin
                    set_v[B_FIRST_FT] = 1'b1;
                end
            end else begin
                set_v[B_NF] = 1'b1;
            end
        end

        keep_v = clr_en ? (sts_q & ~clr_mask) : sts_q;
        sts_d  = keep_v | set_v;
    end

endmodule

// File: rtl/root_err_notify.sv
module root_err_notify
    import root_err_pkg::*;
(
    input  logic [STS_W-1:0] sts_q,
    input  logic [CLS_W-1:0] cmd_q,
    input  logic [CLS_W-1:0] cmd_d,
    input  logic             cmd_wr,
    input  logic             msg_valid,
    input  logic [1:0]       msg_sev,
    input  logic             msix_en,
    input  logic             msi_en,
    input  logic             intx_en,
    input  logic             intx_q,
    output logic             irq_d,
    output logic             irq_msix_d,
    output logic             intx_d
);

    logic [CLS_W-1:0] pend;
    logic             sev_enabled;
    logic             msg_hit;
    logic             cmd_hit;
    logic             msg_mode;

    always_comb begin
        pend        = pending_of(sts_q);
        sev_enabled = 1'b0;
        if (msg_valid && (sev_e'(msg_sev) != SEV_NONE)) begin
            sev_enabled = cmd_q[msg_sev];
        end
        msg_hit  = sev_enabled && ((pend & cmd_q) == '0);
        cmd_hit  = cmd_wr && ((pend & cmd_q) == '0) && ((pend & cmd_d) != '0);
        msg_mode = msix_en || msi_en;

        irq_d      = msg_mode && (msg_hit || cmd_hit);
        irq_msix_d = irq_d && msix_en;

        if (msg_mode || !intx_en) begin
            intx_d = 1'b0;
        end else begin
            intx_d = cmd_wr ? |(cmd_d & pend) : intx_q;
            if (msg_hit) begin
                intx_d = 1'b1;
            end
        end
    end

endmodule

// File: rtl/root_err_collector.sv
module root_err_collector
    import root_err_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             msg_valid,
    input  logic [1:0]       msg_sev,
    input  logic [SRC_W-1:0] msg_src,
    input  logic             serr_en,
    input  logic             cmd_wr,
    input  logic [CLS_W-1:0] cmd_wdata,
    input  logic             sts_clr,
    input  logic [STS_W-1:0] sts_clr_mask,
    input  logic             vec_wr,
    input  logic [VEC_W-1:0] vec_wdata,
    input  logic             msix_en,
    input  logic             msi_en,
    input  logic             intx_en,
    output logic [CLS_W-1:0] root_cmd,
    output logic [STS_W-1:0] root_sts,
    output logic [SRC_W-1:0] cor_src,
    output logic [SRC_W-1:0] unc_src,
    output logic [VEC_W-1:0] irq_vec,
    output logic             msg_irq,
    output logic             msg_irq_msix,
    output logic [VEC_W-1:0] msg_irq_vec,
    output logic             intx_level,
    output logic             sys_err
);

    rec_state_t st_q;
    rec_state_t st_d;

    logic [STS_W-1:0] sts_n;
    logic [SRC_W-1:0] cor_src_n;
    logic [SRC_W-1:0] unc_src_n;
    logic [CLS_W-1:0] cmd_n;
    logic             irq_n;
    logic             irq_msix_n;
    logic             intx_n;

    assign cmd_n = cmd_wr ? cmd_wdata : st_q.cmd;

    root_err_status u_status (
        .sts_q     (st_q.sts),
        .cor_src_q (st_q.cor_src),
        .unc_src_q (st_q.unc_src),
        .msg_valid (msg_valid),
        .msg_sev   (msg_sev),
        .msg_src   (msg_src),
        .clr_en    (sts_clr),
        .clr_mask  (sts_clr_mask),
        .sts_d     (sts_n),
        .cor_src_d (cor_src_n),
        .unc_src_d (unc_src_n)
    );

    root_err_notify u_notify (
        .sts_q      (st_q.sts),
        .cmd_q      (st_q.cmd),
        .cmd_d      (cmd_n),
        .cmd_wr     (cmd_wr),
        .msg_valid  (msg_valid),
        .msg_sev    (msg_sev),
        .msix_en    (msix_en),
        .msi_en     (msi_en),
        .intx_en    (intx_en),
        .intx_q     (st_q.intx),
        .irq_d      (irq_n),
        .irq_msix_d (irq_msix_n),
        .intx_d     (intx_n)
    );

    always_comb begin
        st_d          = st_q;
        st_d.cmd      = cmd_n;
        st_d.sts      = sts_n;
        st_d.cor_src  = cor_src_n;
        st_d.unc_src  = unc_src_n;
        st_d.vec      = vec_wr ? vec_wdata : st_q.vec;
        st_d.irq      = irq_n;
        st_d.irq_msix = irq_msix_n;
        st_d.irq_vec  = irq_n ? st_q.vec : '0;
        st_d.intx     = intx_n;
        st_d.serr     = serr_en && msg_valid &&
                        ((sev_e'(msg_sev) == SEV_NF) || (sev_e'(msg_sev) == SEV_FT));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign root_cmd     = st_q.cmd;
    assign root_sts     = st_q.sts;
    assign cor_src      = st_q.cor_src;
    assign unc_src      = st_q.unc_src;
    assign irq_vec      = st_q.vec;
    assign msg_irq      = st_q.irq;
    assign msg_irq_msix = st_q.irq_msix;
    assign msg_irq_vec  = st_q.irq_vec;
    assign intx_level   = st_q.intx;
    assign sys_err      = st_q.serr;

    // R2: first correctable message captures its identifier
    a_r2_cor_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && msg_sev == 2'd0 && !root_sts[B_COR]) |=> (cor_src == $past(msg_src)));

    // R3: a later uncorrectable message keeps the first identifier
    a_r3_unc_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && (msg_sev == 2'd1 || msg_sev == 2'd2) && root_sts[B_UNC]) |=> $stable(unc_src));

    // R4: fatal message always marks fatal received
    a_r4_fatal_set: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && msg_sev == 2'd2) |=> root_sts[B_FT]);

    // R6: no notification while an enabled class is already pending
    a_r6_no_repeat: assert property (@(posedge clk) disable iff (!rst_n)
        ((pending_of(root_sts) & root_cmd) != '0) |=> !msg_irq);

    // R7: a pulse and the level line never coincide
    a_r7_one_path: assert property (@(posedge clk) disable iff (!rst_n)
        msg_irq |-> !intx_level);

    // R11: the vector only moves on its own load strobe
    a_r11_vec_ro: assert property (@(posedge clk) disable iff (!rst_n)
        !vec_wr |=> $stable(irq_vec));

endmodule

// File: tb/root_err_collector_tb.sv
module root_err_collector_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        msg_valid = 1'b0;
    logic [1:0]  msg_sev = 2'd0;
    logic [15:0] msg_src = 16'h0;
    logic        serr_en = 1'b0;
    logic        cmd_wr = 1'b0;
    logic [2:0]  cmd_wdata = 3'd0;
    logic        sts_clr = 1'b0;
    logic [6:0]  sts_clr_mask = 7'd0;
    logic        vec_wr = 1'b0;
    logic [4:0]  vec_wdata = 5'd0;
    logic        msix_en = 1'b0;
    logic        msi_en = 1'b0;
    logic        intx_en = 1'b0;
    logic [2:0]  root_cmd;
    logic [6:0]  root_sts;
    logic [15:0] cor_src;
    logic [15:0] unc_src;
    logic [4:0]  irq_vec;
    logic        msg_irq;
    logic        msg_irq_msix;
    logic [4:0]  msg_irq_vec;
    logic        intx_level;
    logic        sys_err;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    root_err_collector u_dut (
        .clk(clk), .rst_n(rst_n), .msg_valid(msg_valid), .msg_sev(msg_sev),
        .msg_src(msg_src), .serr_en(serr_en), .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata),
        .sts_clr(sts_clr), .sts_clr_mask(sts_clr_mask), .vec_wr(vec_wr),
        .vec_wdata(vec_wdata), .msix_en(msix_en), .msi_en(msi_en), .intx_en(intx_en),
        .root_cmd(root_cmd), .root_sts(root_sts), .cor_src(cor_src), .unc_src(unc_src),
        .irq_vec(irq_vec), .msg_irq(msg_irq), .msg_irq_msix(msg_irq_msix),
        .msg_irq_vec(msg_irq_vec), .intx_level(intx_level), .sys_err(sys_err)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got=%0h expected=%0h", tag, got, exp);
        end
    endtask

    // each op drives at a falling edge and returns at the next falling edge,
    // where the registered outputs already reflect it
    task automatic send(input logic [1:0] sev, input logic [15:0] src);
        @(negedge clk);
        msg_valid = 1'b1; msg_sev = sev; msg_src = src;
        @(negedge clk);
        msg_valid = 1'b0;
    endtask

    task automatic wr_cmd(input logic [2:0] v);
        @(negedge clk);
        cmd_wr = 1'b1; cmd_wdata = v;
        @(negedge clk);
        cmd_wr = 1'b0;
    endtask

    task automatic clr(input logic [6:0] m);
        @(negedge clk);
        sts_clr = 1'b1; sts_clr_mask = m;
        @(negedge clk);
        sts_clr = 1'b0;
    endtask

    task automatic wr_vec(input logic [4:0] v);
        @(negedge clk);
        vec_wr = 1'b1; vec_wdata = v;
        @(negedge clk);
        vec_wr = 1'b0;
    endtask

    task automatic t_reset;
        check("R1 cmd", {29'd0, root_cmd}, 32'd0);
        check("R1 sts", {25'd0, root_sts}, 32'd0);
        check("R1 src", {cor_src, unc_src}, 32'd0);
        check("R1 outs", {27'd0, irq_vec}, 32'd0);
        check("R1 lines", {29'd0, msg_irq, intx_level, sys_err}, 32'd0);
    endtask

    task automatic t_correctable;
        send(2'd0, 16'h1111);
        check("R2 first sts", {25'd0, root_sts}, 32'h01);
        check("R2 first src", {16'd0, cor_src}, 32'h1111);
        send(2'd0, 16'h2222);
        check("R2 multi sts", {25'd0, root_sts}, 32'h03);
        check("R2 multi src", {16'd0, cor_src}, 32'h1111);
        check("R6 no irq cmd off", {31'd0, msg_irq}, 32'd0);
        clr(7'h7F);
        check("R10 cleared", {25'd0, root_sts}, 32'h00);
    endtask

    task automatic t_uncorrectable;
        send(2'd1, 16'h3333);
        check("R5 nonfatal sts", {25'd0, root_sts}, 32'h24);
        check("R3 first src", {16'd0, unc_src}, 32'h3333);
        send(2'd2, 16'h4444);
        check("R4 fatal after unc", {25'd0, root_sts}, 32'h6C);
        check("R3 src kept", {16'd0, unc_src}, 32'h3333);
        clr(7'h7F);
        send(2'd2, 16'h5555);
        check("R4 first fatal", {25'd0, root_sts}, 32'h54);
        check("R3 fatal src", {16'd0, unc_src}, 32'h5555);
        send(2'd3, 16'h6666);
        check("R5 sev3 ignored", {25'd0, root_sts}, 32'h54);
        check("R5 sev3 src", {cor_src, unc_src}, {16'h1111, 16'h5555});
        clr(7'h10);
        check("R10 partial clear", {25'd0, root_sts}, 32'h44);
        clr(7'h7F);
    endtask

    task automatic t_notify;
        msi_en = 1'b1;
        wr_vec(5'd9);
        check("R11 vec load", {27'd0, irq_vec}, 32'd9);
        wr_cmd(3'b111);
        check("R9 no pending no pulse", {31'd0, msg_irq}, 32'd0);
        send(2'd0, 16'h0001);
        check("R6 first pulse", {31'd0, msg_irq}, 32'd1);
        check("R7 vector", {27'd0, msg_irq_vec}, 32'd9);
        check("R7 msi path", {31'd0, msg_irq_msix}, 32'd0);
        @(negedge clk);
        check("R7 one cycle", {31'd0, msg_irq}, 32'd0);
        send(2'd0, 16'h0002);
        check("R6 repeat silent", {31'd0, msg_irq}, 32'd0);
        send(2'd2, 16'h0003);
        check("R6 other class silent", {31'd0, msg_irq}, 32'd0);
        clr(7'h7F);
        check("R11 vec after clear", {27'd0, irq_vec}, 32'd9);
        wr_cmd(3'b100);
        send(2'd0, 16'h0004);
        check("R6 disabled class", {31'd0, msg_irq}, 32'd0);
        send(2'd2, 16'h0005);
        check("R6 new enabled class", {31'd0, msg_irq}, 32'd1);
        clr(7'h7F);
    endtask

    task automatic t_cmd_write;
        wr_cmd(3'b000);
        send(2'd1, 16'h0010);
        check("R6 cmd zero", {31'd0, msg_irq}, 32'd0);
        wr_cmd(3'b010);
        check("R9 becomes enabled", {31'd0, msg_irq}, 32'd1);
        wr_cmd(3'b011);
        check("R9 already enabled", {31'd0, msg_irq}, 32'd0);
        msix_en = 1'b1;
        wr_cmd(3'b000);
        wr_cmd(3'b010);
        check("R7 msix pulse", {31'd0, msg_irq}, 32'd1);
        check("R7 msix preferred", {31'd0, msg_irq_msix}, 32'd1);
        check("R11 vec after cmd", {27'd0, irq_vec}, 32'd9);
        msix_en = 1'b0;
        msi_en = 1'b0;
    endtask

    task automatic t_intx;
        intx_en = 1'b1;
        wr_cmd(3'b010);
        check("R8 level on write", {31'd0, intx_level}, 32'd1);
        check("R8 no pulse", {31'd0, msg_irq}, 32'd0);
        wr_cmd(3'b001);
        check("R8 level off write", {31'd0, intx_level}, 32'd0);
        clr(7'h7F);
        send(2'd0, 16'h0020);
        check("R8 level on notify", {31'd0, intx_level}, 32'd1);
        msi_en = 1'b1;
        @(negedge clk);
        check("R8 low in msg mode", {31'd0, intx_level}, 32'd0);
        msi_en = 1'b0;
        intx_en = 1'b0;
        clr(7'h7F);
    endtask

    task automatic t_serr;
        serr_en = 1'b1;
        send(2'd2, 16'h0030);
        check("R12 fatal serr", {31'd0, sys_err}, 32'd1);
        @(negedge clk);
        check("R12 serr pulse ends", {31'd0, sys_err}, 32'd0);
        send(2'd0, 16'h0031);
        check("R12 cor no serr", {31'd0, sys_err}, 32'd0);
        serr_en = 1'b0;
        send(2'd1, 16'h0032);
        check("R12 disabled", {31'd0, sys_err}, 32'd0);
    endtask

    task automatic t_set_wins;
        clr(7'h7F);
        @(negedge clk);
        sts_clr = 1'b1; sts_clr_mask = 7'h7F;
        msg_valid = 1'b1; msg_sev = 2'd0; msg_src = 16'h0040;
        @(negedge clk);
        sts_clr = 1'b0; msg_valid = 1'b0;
        check("R10 set wins", {25'd0, root_sts}, 32'h01);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_correctable();
        t_uncorrectable();
        t_notify();
        t_cmd_write();
        t_intx();
        t_serr();
        t_set_wins();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired got=running expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule